// File: doc/BRIEF.md
# City-Block Nearest-Neighbour Template Matcher

This block classifies a face query by nearest-neighbour search under the city-block (L1) metric. A query holds three feature vectors of 40 elements each: one for the eye region, one for the nose region and one for the mouth region. Each enrolled template in an internal memory holds the same three vectors. The block compares each query region only with the same region of the template. It adds the absolute differences of all 120 element pairs into one total distance for that template.

Software first writes templates through an addressed write port. It then streams the 120 query elements and pulses `start`. The block walks the valid templates in ascending index order, one element per clock. It keeps the smallest total seen so far. When the scan ends, it emits the winning index and its distance for one cycle. It also raises a match flag when that distance lies below a programmable threshold.

Top module: `l1_nn_matcher`

## Requirements
- R1: The distance of template t is the sum over e in 0..119 of |T[t][e] - Q[e]|. Element e = region*40 + k, with region 0 = eye, 1 = nose and 2 = mouth. Template element e is written with `tpl_elem` = e. Query elements are taken from `q_data` in stream order 0..119, one per cycle in which `q_valid` is high while idle. The stream position returns to 0 when a start is accepted.
- R2: When a scan ends, `res_index` carries the index of the template with the smallest distance and `res_dist` carries that distance.
- R3: When two or more templates share the smallest distance, the lowest index among them is reported.
- R4: Only templates 0..`tpl_count`-1 take part in the search. A `tpl_count` above MAX_TPL (default 16) is treated as MAX_TPL.
- R5: A start with `tpl_count` = 0 performs no scan. On the next cycle it gives `res_valid` = 1, `res_match` = 0, `res_index` = 0 and `res_dist` = all ones.
- R6: `busy` rises on the cycle after an accepted start with a nonzero count and stays high for the scan. `res_valid` is a single-cycle pulse and coincides with `busy` falling.
- R7: `res_match` is 1 exactly when `res_dist` < `threshold`. The compare is strict.
- R8: Template writes, query elements and `start` presented while `busy` is high are ignored.
- R9: The distance never wraps. With every element differing by 255, the reported distance is 120*255 = 30600.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tpl_we | input | 1 | Template element write strobe |
| tpl_sel | input | 4 | Template index to write |
| tpl_elem | input | 7 | Element position region*40+k |
| tpl_data | input | 8 | Template element value |
| q_valid | input | 1 | Query element present |
| q_data | input | 8 | Query element value |
| tpl_count | input | 5 | Number of valid templates |
| threshold | input | 15 | Match limit on the distance |
| start | input | 1 | Begin a search |
| busy | output | 1 | Scan in progress |
| res_valid | output | 1 | Result strobe |
| res_index | output | 4 | Best template index |
| res_dist | output | 15 | Best distance |
| res_match | output | 1 | Distance below threshold |

## Verification
Random templates and queries drawn from the full 8-bit range give well-separated distances. These show whether the right minimum is found and summed correctly across all three regions. Random values limited to 0..3 produce frequent equal distances, which expose any bias away from the lowest index. Directed cases cover the following: identical templates, two equal winners placed after a worse one, all-maximum differences for overflow, threshold at and just above the distance, a zero count, an oversized count, and writes, query data and starts applied during a scan.

// File: rtl/l1_nn_matcher.sv
module l1_nn_matcher #(
  parameter int ELEM_W  = 8,
  parameter int VEC_LEN = 40,
  parameter int REGIONS = 3,
  parameter int MAX_TPL = 16
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           tpl_we,
  input  logic [$clog2(MAX_TPL)-1:0]                     tpl_sel,
  input  logic [$clog2(VEC_LEN*REGIONS)-1:0]             tpl_elem,
  input  logic [ELEM_W-1:0]                              tpl_data,
  input  logic                                           q_valid,
  input  logic [ELEM_W-1:0]                              q_data,
  input  logic [$clog2(MAX_TPL+1)-1:0]                   tpl_count,
  input  logic [ELEM_W+$clog2(VEC_LEN*REGIONS+1)-1:0]    threshold,
  input  logic                                           start,
  output logic                                           busy,
  output logic                                           res_valid,
  output logic [$clog2(MAX_TPL)-1:0]                     res_index,
  output logic [ELEM_W+$clog2(VEC_LEN*REGIONS+1)-1:0]    res_dist,
  output logic                                           res_match
);
  localparam int FEAT_N = VEC_LEN * REGIONS;
  localparam int EIDX_W = $clog2(FEAT_N);
  localparam int QP_W   = $clog2(FEAT_N + 1);
  localparam int TIDX_W = $clog2(MAX_TPL);
  localparam int CNT_W  = $clog2(MAX_TPL + 1);
  localparam int DIST_W = ELEM_W + $clog2(FEAT_N + 1);
  localparam int ADDR_W = $clog2(MAX_TPL * FEAT_N);

  logic [ELEM_W-1:0] tmem [MAX_TPL*FEAT_N];
  logic [ELEM_W-1:0] qmem [FEAT_N];

  logic [QP_W-1:0]   q_ptr;
  logic [TIDX_W-1:0] cur_t, last_t, min_i, nxt_i;
  logic [EIDX_W-1:0] cur_e;
  logic [DIST_W-1:0] acc, min_d, sum, nxt_d;
  logic [ELEM_W-1:0] rd_t, rd_q, diff;
  logic [CNT_W-1:0]  eff_cnt;
  logic              better, last_e, last_tpl, q_take;

  assign eff_cnt  = (tpl_count > CNT_W'(MAX_TPL)) ? CNT_W'(MAX_TPL) : tpl_count;
  assign rd_t     = tmem[ADDR_W'(cur_t) * ADDR_W'(FEAT_N) + ADDR_W'(cur_e)];
  assign rd_q     = qmem[cur_e];
  assign diff     = (rd_t > rd_q) ? rd_t - rd_q : rd_q - rd_t;
  assign sum      = acc + DIST_W'(diff);
  assign better   = sum < min_d;
  assign nxt_d    = better ? sum : min_d;
  assign nxt_i    = better ? cur_t : min_i;
  assign last_e   = cur_e == EIDX_W'(FEAT_N - 1);
  assign last_tpl = cur_t == last_t;
  assign q_take   = !busy && !start && q_valid && (q_ptr < QP_W'(FEAT_N));

  always_ff @(posedge clk) begin
    if (!busy && tpl_we && (tpl_elem < EIDX_W'(FEAT_N)))
      tmem[ADDR_W'(tpl_sel) * ADDR_W'(FEAT_N) + ADDR_W'(tpl_elem)] <= tpl_data;
    if (q_take)
      qmem[EIDX_W'(q_ptr)] <= q_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      res_valid <= 1'b0;
      res_index <= '0;
      res_dist  <= '1;
      res_match <= 1'b0;
      q_ptr     <= '0;
      cur_t     <= '0;
      cur_e     <= '0;
      last_t    <= '0;
      acc       <= '0;
      min_d     <= '1;
      min_i     <= '0;
    end else begin
      res_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          q_ptr <= '0;
          if (eff_cnt == '0) begin
            res_valid <= 1'b1;
            res_match <= 1'b0;
            res_index <= '0;
            res_dist  <= '1;
          end else begin
            busy   <= 1'b1;
            cur_t  <= '0;
            cur_e  <= '0;
            acc    <= '0;
            min_d  <= '1;
            min_i  <= '0;
            last_t <= TIDX_W'(eff_cnt - CNT_W'(1));
          end
        end else if (q_take) begin
          q_ptr <= q_ptr + QP_W'(1);
        end
      end else if (last_e) begin
        acc   <= '0;
        cur_e <= '0;
        min_d <= nxt_d;
        min_i <= nxt_i;
        if (last_tpl) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res_dist  <= nxt_d;
          res_index <= nxt_i;
          res_match <= nxt_d < threshold;
        end else begin
          cur_t <= cur_t + TIDX_W'(1);
        end
      end else begin
        acc   <= sum;
        cur_e <= cur_e + EIDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/l1_nn_matcher_chk.sv
module l1_nn_matcher_chk #(
  parameter int ELEM_W  = 8,
  parameter int VEC_LEN = 40,
  parameter int REGIONS = 3,
  parameter int MAX_TPL = 16
) (
  input logic                                        clk,
  input logic                                        rst_n,
  input logic [$clog2(MAX_TPL+1)-1:0]                tpl_count,
  input logic [ELEM_W+$clog2(VEC_LEN*REGIONS+1)-1:0] threshold,
  input logic                                        start,
  input logic                                        busy,
  input logic                                        res_valid,
  input logic [ELEM_W+$clog2(VEC_LEN*REGIONS+1)-1:0] res_dist,
  input logic                                        res_match
);
  localparam int DIST_W   = ELEM_W + $clog2(VEC_LEN*REGIONS + 1);
  localparam int MAX_DIST = VEC_LEN * REGIONS * ((1 << ELEM_W) - 1);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R6
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && tpl_count != '0) |=> busy); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy); // R6
  AST_EMPTY_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && tpl_count == '0) |=> (res_valid && !res_match && res_dist == '1)); // R5
  AST_MATCH_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $stable(threshold)) |-> (res_match == (res_dist < threshold))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && tpl_count != '0 && $stable(tpl_count)) |-> (res_dist <= DIST_W'(MAX_DIST))); // R9
endmodule

bind l1_nn_matcher l1_nn_matcher_chk #(
  .ELEM_W(ELEM_W), .VEC_LEN(VEC_LEN), .REGIONS(REGIONS), .MAX_TPL(MAX_TPL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tpl_count(tpl_count), .threshold(threshold),
  .start(start), .busy(busy), .res_valid(res_valid), .res_dist(res_dist),
  .res_match(res_match)
);

// File: tb/l1_nn_matcher_tb.sv
`timescale 1ns/1ps
module l1_nn_matcher_tb;
  localparam int ELEM_W = 8, VEC_LEN = 40, REGIONS = 3, MAX_TPL = 16;
  localparam int FEAT_N = VEC_LEN * REGIONS;
  localparam int TIDX_W = $clog2(MAX_TPL);
  localparam int EIDX_W = $clog2(FEAT_N);
  localparam int CNT_W  = $clog2(MAX_TPL + 1);
  localparam int DIST_W = ELEM_W + $clog2(FEAT_N + 1);
  localparam int ONES   = (1 << DIST_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tpl_we = 1'b0, q_valid = 1'b0, start = 1'b0;
  logic [TIDX_W-1:0] tpl_sel = '0;
  logic [EIDX_W-1:0] tpl_elem = '0;
  logic [ELEM_W-1:0] tpl_data = '0, q_data = '0;
  logic [CNT_W-1:0]  tpl_count = '0;
  logic [DIST_W-1:0] threshold = '0;
  logic busy, res_valid, res_match;
  logic [TIDX_W-1:0] res_index;
  logic [DIST_W-1:0] res_dist;

  int checks = 0, fails = 0;
  int tm [MAX_TPL][FEAT_N];
  int qm [FEAT_N];

  always #2.5 clk = ~clk;

  l1_nn_matcher #(.ELEM_W(ELEM_W), .VEC_LEN(VEC_LEN), .REGIONS(REGIONS), .MAX_TPL(MAX_TPL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tpl_we(tpl_we), .tpl_sel(tpl_sel), .tpl_elem(tpl_elem),
    .tpl_data(tpl_data), .q_valid(q_valid), .q_data(q_data), .tpl_count(tpl_count),
    .threshold(threshold), .start(start), .busy(busy), .res_valid(res_valid),
    .res_index(res_index), .res_dist(res_dist), .res_match(res_match));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void ref_best(input int cnt, output int bi, output int bd);
    int n = (cnt > MAX_TPL) ? MAX_TPL : cnt;
    bi = 0; bd = ONES;
    for (int t = 0; t < n; t++) begin
      int d = 0;
      for (int e = 0; e < FEAT_N; e++) d += (tm[t][e] > qm[e]) ? tm[t][e] - qm[e] : qm[e] - tm[t][e];
      if (d < bd) begin bd = d; bi = t; end
    end
  endfunction

  task automatic load_tpl(input int t);
    for (int e = 0; e < FEAT_N; e++) begin
      @(negedge clk);
      tpl_we = 1'b1; tpl_sel = TIDX_W'(t); tpl_elem = EIDX_W'(e); tpl_data = ELEM_W'(tm[t][e]);
    end
    @(negedge clk); tpl_we = 1'b0;
  endtask

  task automatic load_query();
    for (int e = 0; e < FEAT_N; e++) begin
      @(negedge clk); q_valid = 1'b1; q_data = ELEM_W'(qm[e]);
    end
    @(negedge clk); q_valid = 1'b0;
  endtask

  task automatic wait_result();
    int n = 0;
    while (!res_valid && n < 3000) begin @(negedge clk); n++; end
    if (!res_valid) begin fails++; $display("FAIL R6 actual=timeout expected=res_valid"); end
  endtask

  task automatic run_scan(input int cnt, input int thr, input string tag);
    int bi, bd;
    ref_best(cnt, bi, bd);
    @(negedge clk);
    tpl_count = CNT_W'(cnt); threshold = DIST_W'(thr); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (cnt != 0) chk("R6 busy after start", int'(busy), 1);
    wait_result();
    chk({tag, " index"}, int'(res_index), bi);
    chk({tag, " dist"}, int'(res_dist), bd);
    chk("R7 match", int'(res_match), (bd < thr) ? 1 : 0);
    @(negedge clk);
    chk("R6 single pulse", int'(res_valid), 0);
  endtask

  task automatic fill_all(input int maxv);
    for (int t = 0; t < MAX_TPL; t++) begin
      for (int e = 0; e < FEAT_N; e++) tm[t][e] = int'($urandom_range(maxv, 0));
      load_tpl(t);
    end
    for (int e = 0; e < FEAT_N; e++) qm[e] = int'($urandom_range(maxv, 0));
    load_query();
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bi, bd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset busy", int'(busy), 0);
    chk("R6 reset valid", int'(res_valid), 0);

    // R5 empty store
    run_scan(0, 100, "R5 empty");

    // R1 R2 full-range random
    for (int r = 0; r < 5; r++) begin
      fill_all(255);
      run_scan(int'($urandom_range(MAX_TPL, 1)), int'($urandom_range(20000, 0)), "R1 R2 random");
    end
    // R3 narrow-range random to provoke ties
    for (int r = 0; r < 4; r++) begin
      fill_all(3);
      run_scan(int'($urandom_range(MAX_TPL, 1)), int'($urandom_range(200, 0)), "R3 narrow");
    end

    // R4 oversized count clamps
    run_scan(20, 30000, "R4 clamp");
    run_scan(3, 30000, "R4 partial");

    // R3 identical templates and tie after a worse one
    for (int e = 0; e < FEAT_N; e++) qm[e] = 50;
    load_query();
    for (int t = 0; t < MAX_TPL; t++) begin
      for (int e = 0; e < FEAT_N; e++) tm[t][e] = 60;
      load_tpl(t);
    end
    run_scan(MAX_TPL, 1200, "R3 all equal");
    for (int e = 0; e < FEAT_N; e++) begin tm[0][e] = 90; tm[4][e] = 52; tm[9][e] = 48; end
    load_tpl(0); load_tpl(4); load_tpl(9);
    load_query();
    run_scan(MAX_TPL, 241, "R3 tie");

    // R9 R7 saturated differences, threshold boundary
    for (int e = 0; e < FEAT_N; e++) begin tm[0][e] = 255; qm[e] = 0; end
    load_tpl(0);
    load_query();
    run_scan(1, 30600, "R9 max");
    load_query();
    run_scan(1, 30601, "R9 max");

    // R8 writes, query data and start during a scan are ignored
    fill_all(255);
    ref_best(MAX_TPL, bi, bd);
    @(negedge clk);
    tpl_count = CNT_W'(MAX_TPL); threshold = DIST_W'(0); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int e = 0; e < 40; e++) begin
      @(negedge clk);
      tpl_we = 1'b1; tpl_sel = TIDX_W'(e % MAX_TPL); tpl_elem = EIDX_W'(e); tpl_data = ELEM_W'(qm[e]);
      q_valid = 1'b1; q_data = ELEM_W'(~qm[e]); start = 1'b1;
    end
    @(negedge clk); tpl_we = 1'b0; q_valid = 1'b0; start = 1'b0;
    wait_result();
    chk("R8 busy-time index", int'(res_index), bi);
    chk("R8 busy-time dist", int'(res_dist), bd);
    load_query();
    run_scan(MAX_TPL, 0, "R8 after busy writes");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule